// File: doc/BRIEF.md
# Recursive Q15 Sine Oscillator

This block produces a stream of signed 16-bit sine samples without a lookup table. It keeps two Q15 state words, a cosine-like term and a sine-like term. Each step rotates them by a small angle set by a Q15 coefficient `step_coef`, in a coupled (circle) recurrence. The second half of each step already uses the freshly updated first state, which keeps the recurrence stable indefinitely without renormalisation.

A host computes the coefficient from the wanted tone, twice the sine of pi·f/fs scaled by 32767 (for example 1630 for about 349 Hz at 44.1 kHz). The host pulses `load` to apply the coefficient together with a starting amplitude, then pulses `sample_req` once per output sample, typically from a serial audio transmitter's data request. Each request produces one new sample with a single-cycle `sample_vld` strobe.

Top module: `q15_sine_osc`

## Requirements
- R1: After reset, `sample_vld` is 0, `sample_out` is 0, the rotating term is 0, the amplitude term is 29490 and the coefficient is 1630. A request issued with no prior load steps from this state.
- R2: A `load` pulse sets the rotating term to 0, the amplitude term to `init_amp` and the coefficient to `step_coef`. It abandons a step in progress and discards a held request. A `sample_req` in the same cycle as `load` is ignored: no strobe follows it.
- R3: The first half of a step adds to the rotating term the product coefficient × amplitude term. The product is formed as a 32-bit signed value, shifted right arithmetically by 15 and truncated to 16 bits. The amplitude term does not change in that cycle.
- R4: The second half of a step subtracts from the amplitude term the product coefficient × rotating term, using the rotating term already updated in the first half. The product is scaled and truncated the same way as in R3.
- R5: `sample_out` equals the rotating term after the step completes, in two's complement. It holds its value until the next completed step.
- R6: A request sampled at rising edge N with the block idle gives `sample_vld` high after edge N+1, for exactly one cycle.
- R7: A request arriving while a step is in progress is held and serviced right after that step, so it produces its own strobe. Requests within one busy cycle collapse into one.
- R8: All sums and differences wrap modulo 2^16. For example, coefficient −32768 with amplitude −32768 gives samples −32768, then −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Pulse: apply `step_coef` and `init_amp`, clear the rotating term |
| step_coef | input | 16 | Signed Q15 rotation coefficient |
| init_amp | input | 16 | Signed Q15 starting amplitude |
| sample_req | input | 1 | Pulse: advance one step |
| sample_out | output | 16 | Signed Q15 sample |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |

## Verification
Two pairs of functions can fall in the same cycle. The first is a new request against a step still in its second half. The bench provokes it by holding the request for two consecutive cycles and judges it by two separate strobes, whose second sample is the model's second step. The second is a load against a request or a busy step. The bench raises load together with a request, and also one cycle after a request. It expects no strobe in the following cycles, and a later request must give exactly the first step computed from the newly loaded state.

// File: rtl/q15_osc_pkg.sv
package q15_osc_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   pend;
    } ctrl_t;

endpackage

// File: rtl/q15_mulscale.sv
module q15_mulscale #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    localparam int PW = 2 * W;
    localparam int SH = W - 1;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] prod;

    always_comb begin
        a_ext = {{W{a[W-1]}}, a};
        b_ext = {{W{b[W-1]}}, b};
        prod  = a_ext * b_ext;
        p     = W'(prod >>> SH);
    end

endmodule

// File: rtl/q15_step_ctrl.sv
module q15_step_ctrl
    import q15_osc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic req,
    output logic do_x,
    output logic do_y
);
    ctrl_t st_d, st_q;
    logic  go;

    always_comb begin
        st_d = st_q;
        go   = req | st_q.pend;
        do_x = 1'b0;
        do_y = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            st_d.pend = 1'b0;
            if (!load && go) begin
                do_x       = 1'b1;
                st_d.phase = PH_BUSY;
            end
        end else begin
            st_d.phase = PH_IDLE;
            do_y       = !load;
            st_d.pend  = req & !load;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // a request held during the busy cycle starts the next step at once
    assert_pending_served_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_BUSY && req && !load) ##1 !load |-> do_x);

    // first half is followed by the second half unless load cuts in
    assert_second_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_x ##1 !load |-> do_y);

    assert_no_step_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !do_x && !do_y);

endmodule

// File: rtl/q15_sine_osc.sv
module q15_sine_osc #(
    parameter int          W             = 16,
    parameter logic [15:0] AMP_DEFAULT   = 16'd29490,
    parameter logic [15:0] DELTA_DEFAULT = 16'd1630
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  step_coef,
    input  logic [W-1:0]  init_amp,
    input  logic          sample_req,
    output logic [W-1:0]  sample_out,
    output logic          sample_vld
);
    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] d;
        logic [W-1:0] smp;
        logic         vld;
    } dp_t;

    dp_t          dp_d, dp_q;
    logic         do_x, do_y;
    logic [W-1:0] prod_dy, prod_dx;

    q15_step_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .req   (sample_req),
        .do_x  (do_x),
        .do_y  (do_y)
    );

    q15_mulscale #(.W(W)) u_mul_dy (
        .a (dp_q.d),
        .b (dp_q.y),
        .p (prod_dy)
    );

    q15_mulscale #(.W(W)) u_mul_dx (
        .a (dp_q.d),
        .b (dp_q.x),
        .p (prod_dx)
    );

    always_comb begin
        dp_d     = dp_q;
        dp_d.vld = 1'b0;
        if (load) begin
            dp_d.x = '0;
            dp_d.y = init_amp;
            dp_d.d = step_coef;
        end else begin
            if (do_x) begin
                dp_d.x = dp_q.x + prod_dy;
            end
            if (do_y) begin
                dp_d.y   = dp_q.y - prod_dx;
                dp_d.smp = dp_q.x;
                dp_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '{x: '0, y: W'(AMP_DEFAULT), d: W'(DELTA_DEFAULT), smp: '0, vld: 1'b0};
        end else begin
            dp_q <= dp_d;
        end
    end

    assign sample_out = dp_q.smp;
    assign sample_vld = dp_q.vld;

    assert_load_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dp_q.x == '0 && dp_q.y == $past(init_amp) &&
                  dp_q.d == $past(step_coef) && !sample_vld));

    assert_y_hold_first_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_x |=> $stable(dp_q.y));

    assert_sample_is_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> sample_out == dp_q.x);

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_x ##1 !load |=> sample_vld);

    assert_sample_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> sample_out == $past(sample_out));

endmodule

// File: tb/q15_sine_osc_test.sv
module q15_sine_osc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] step_coef = '0;
    logic [15:0] init_amp = '0;
    logic        sample_req = 1'b0;
    logic [15:0] sample_out;
    logic        sample_vld;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_x, m_y, m_d;

    always #5 clk = ~clk;

    q15_sine_osc uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step_coef  (step_coef),
        .init_amp   (init_amp),
        .sample_req (sample_req),
        .sample_out (sample_out),
        .sample_vld (sample_vld)
    );

    function automatic logic [15:0] mulq(logic [15:0] a, logic [15:0] b);
        int p;
        int s;
        p = int'($signed(a)) * int'($signed(b));
        s = p >>> 15;
        return s[15:0];
    endfunction

    // advance the reference model by one step, return the new sample
    function automatic logic [15:0] model_step();
        m_x = m_x + mulq(m_d, m_y);
        m_y = m_y - mulq(m_d, m_x);
        return m_x;
    endfunction

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_load(input logic [15:0] c, input logic [15:0] a);
        m_x = '0;
        m_y = a;
        m_d = c;
    endtask

    // one request, checks latency (R6), sample (R3/R4/R5) and strobe width
    task automatic step_check(input string tag);
        logic [15:0] e;
        e = model_step();
        sample_req = 1'b1;
        @(negedge clk);
        sample_req = 1'b0;
        check(sample_vld == 1'b0, {tag, " R6 early strobe"}, sample_vld, 0);
        @(negedge clk);
        check(sample_vld == 1'b1, {tag, " R6 strobe"}, sample_vld, 1);
        check(sample_out == e, {tag, " R5 sample"}, $signed(sample_out), $signed(e));
        @(negedge clk);
        check(sample_vld == 1'b0, {tag, " R6 one cycle"}, sample_vld, 0);
        check(sample_out == e, {tag, " R5 hold"}, $signed(sample_out), $signed(e));
    endtask

    task automatic do_load(input logic [15:0] c, input logic [15:0] a);
        load = 1'b1;
        step_coef = c;
        init_amp = a;
        @(negedge clk);
        load = 1'b0;
        model_load(c, a);
    endtask

    task automatic t_reset();
        check(sample_vld == 1'b0, "R1 reset strobe", sample_vld, 0);
        check(sample_out == 16'd0, "R1 reset sample", sample_out, 0);
        model_load(16'd1630, 16'd29490);
        step_check("R1 default step");
        step_check("R1 default step2");
    endtask

    task automatic t_tone();
        do_load(16'd1630, 16'd29490);
        for (int i = 0; i < 40; i++) step_check("R3 R4 tone");
    endtask

    task automatic t_negative();
        do_load(16'hEC78, 16'hB1E0);
        for (int i = 0; i < 12; i++) step_check("R3 negative coef");
    endtask

    task automatic t_wrap();
        do_load(16'h8000, 16'h8000);
        step_check("R8 wrap step1");
        check(m_x == 16'h8000, "R8 model step1", m_x, 16'h8000);
        step_check("R8 wrap step2");
        check(sample_out == 16'h8000, "R8 step2 value", sample_out, 16'h8000);
        for (int i = 0; i < 4; i++) step_check("R8 wrap run");
    endtask

    task automatic t_pending();
        logic [15:0] e1, e2;
        do_load(16'd5000, 16'd20000);
        e1 = model_step();
        e2 = model_step();
        sample_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sample_req = 1'b0;
        check(sample_vld == 1'b1, "R7 first strobe", sample_vld, 1);
        check(sample_out == e1, "R7 first sample", $signed(sample_out), $signed(e1));
        @(negedge clk);
        check(sample_vld == 1'b0, "R7 gap", sample_vld, 0);
        @(negedge clk);
        check(sample_vld == 1'b1, "R7 held request strobe", sample_vld, 1);
        check(sample_out == e2, "R7 second sample", $signed(sample_out), $signed(e2));
        @(negedge clk);
        check(sample_vld == 1'b0, "R7 no third strobe", sample_vld, 0);
        step_check("R7 after pending");
    endtask

    task automatic t_load_collide();
        int seen;
        // request in the same cycle as load is ignored
        load = 1'b1;
        sample_req = 1'b1;
        step_coef = 16'd3000;
        init_amp = 16'd15000;
        @(negedge clk);
        load = 1'b0;
        sample_req = 1'b0;
        model_load(16'd3000, 16'd15000);
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            if (sample_vld) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R2 request with load ignored", seen, 0);
        step_check("R2 fresh after load");
        // load during the busy cycle abandons the step
        sample_req = 1'b1;
        @(negedge clk);
        sample_req = 1'b0;
        load = 1'b1;
        step_coef = 16'd1200;
        init_amp = 16'd10000;
        @(negedge clk);
        load = 1'b0;
        model_load(16'd1200, 16'd10000);
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            if (sample_vld) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R2 busy step abandoned", seen, 0);
        step_check("R2 first step after abort");
        step_check("R2 second step after abort");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R6: watchdog expired, got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tone();
        t_negative();
        t_wrap();
        t_pending();
        t_load_collide();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule